// File: doc/BRIEF.md
# Skip-Aware Nibble-Machine Instruction Sequencer

This block is the fetch and sequencing controller of a small 4-bit microcontroller core. Every instruction slot, it looks at the byte at the program counter and at the byte after it, and classifies the instruction. It then takes one of three actions. It can hand the instruction to the datapath with an execute strobe. It can discard the instruction because a skip is pending. Or it can replace the instruction with entry into the single external interrupt. The datapath, RAM, stack storage and I/O pins sit outside the block. The datapath answers each execute strobe with a skip request and, for returns and computed jumps, with a program-counter load. The sequencer itself computes the successor address for straight-line code and for direct jumps.

Two bytes, 0x23 and 0x33, act as escape codes. Each opens a two-byte instruction whose second byte is passed to the datapath as the argument. A discarded instruction is always stepped over whole, whatever its length. Every slot is reported as a step with its kind, address and cost in machine cycles. An executed slot takes two clocks: the dispatch clock and one settle clock in which the datapath responds. Discarded slots and interrupt entries take one clock each.

Top module: `nib_seq`

## Requirements
- R1: While reset is low, rom_addr is 0 and exec_valid, push_valid, step_valid and irq_taken are all 0. Reset clears the skip flag, the address-load run flag, the saved-skip bit, the interrupt enable and the wake history.
- R2: Opcodes 0x23 and 0x33 are escape bytes. Such an instruction is two bytes long, and its second byte appears on exec_arg. It costs 2 cycles, and the next slot starts 2 bytes further on.
- R3: The datapath raises dp_skip during the clock in which exec_valid is high. The next instruction is then discarded (step_kind 1) with no execute strobe. The counter advances by that instruction's full length (1 or 2 bytes), and the skip then clears.
- R4: A discarded 0xBF or 0xFF (the one-byte indirect load and indirect jump) reports a cost of 1 instead of 2. Any other discarded instruction reports its normal cost.
- R5: An address-load is any one-byte opcode with bits[7:6]=00 and bit 3 set, or the escape 0x33 followed by a byte with bits[7:6]=10 and a low nibble from 1 to 8. Executing one starts a run. Every address-load met during a run is discarded at its normal cost. The first opcode that is not an address-load ends the run and executes.
- R6: An address-load that is discarded because of a pending skip does not start a run.
- R7: 0x60-0x63 (long jump) and 0x68-0x6B (long call) are two bytes long and cost 2. The target is {opcode[1:0], second byte}. A long call pushes its own address + 2.
- R8: Opcodes 0x80-0xFE other than 0xBF use the address after the opcode, P. If P[9:7]=001, the target is {P[9:7], opcode[6:0]}. Otherwise, when opcode[7:6]=11 the target is {P[9:6], opcode[5:0]}. In the remaining case the instruction pushes P and jumps to 0x080 | opcode[5:0].
- R9: An interrupt is taken at a slot boundary when the enable is set, the wake history holds 1, and wake_in is now 0. With the enable clear, a falling wake_in has no effect.
- R10: No interrupt is taken while a run is active, or when the pending instruction is a long jump, long call, or 0x80-0xFE (other than 0xBF). The wake history samples wake_in at each boundary where the enable is set and no interrupt is taken.
- R11: On interrupt entry, step_kind is 2 with cost 1. The address of the pre-empted instruction is pushed, the counter loads 0x0FF, the enable clears, and the pending skip moves to the saved-skip bit and clears.
- R12: Executing the return opcode 0x48 reloads the skip flag from the saved-skip bit, instead of from dp_skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | PC_W | Program counter; address of the first opcode byte |
| rom_addr_nxt | output | PC_W | Address of the byte after the opcode |
| rom_byte0 | input | 8 | ROM data at rom_addr |
| rom_byte1 | input | 8 | ROM data at rom_addr_nxt |
| wake_in | input | 1 | External interrupt line, falling-edge sensitive |
| dp_skip | input | 1 | Datapath asks to discard the next instruction (settle clock) |
| dp_pc_load | input | 1 | Datapath overrides the counter (settle clock) |
| dp_pc_addr | input | PC_W | Counter value for dp_pc_load |
| irq_en_load | input | 1 | Datapath writes the interrupt enable (settle clock) |
| irq_en_val | input | 1 | Value written to the interrupt enable |
| exec_valid | output | 1 | Execute strobe, high for the settle clock |
| exec_op | output | 8 | First byte of the executed instruction |
| exec_arg | output | 8 | Second byte of the executed instruction |
| push_valid | output | 1 | Return address push request |
| push_pc | output | PC_W | Return address to push |
| step_valid | output | 1 | One slot completed |
| step_kind | output | 2 | 0 executed, 1 discarded, 2 interrupt entry |
| step_pc | output | PC_W | Address of the slot |
| step_cycles | output | 2 | Machine-cycle cost of the slot |
| irq_taken | output | 1 | Interrupt entry in this slot |

## Verification
A wrong skip, run or saved-skip bit shows at the ports within the next step. The step stream then reports an execute where a discard was due, or the reverse. Because a discard moves the counter by the instruction's length, the address of every later step is also wrong. A wrong length decode or jump target shows as a wrong step_pc on the very next step. A wrong wake history or enable shows as an interrupt step missing, or appearing one or more slots out of place. The bench therefore compares every step's kind, address and cost against hand-derived programs, including one where the return must re-arm a skip that was pending when the interrupt arrived.

// File: rtl/nib_seq_pkg.sv
package nib_seq_pkg;

    localparam logic [7:0] ESC_A    = 8'h23;
    localparam logic [7:0] ESC_B    = 8'h33;
    localparam logic [7:0] IND_LOAD = 8'hBF;
    localparam logic [7:0] IND_JUMP = 8'hFF;

    typedef enum logic [1:0] {
        SK_EXEC = 2'd0,
        SK_DROP = 2'd1,
        SK_IRQ  = 2'd2
    } step_kind_e;

    typedef enum logic [1:0] {
        FL_PLAIN = 2'd0,
        FL_LJMP  = 2'd1,
        FL_LCALL = 2'd2,
        FL_PAGE  = 2'd3
    } flow_e;

    typedef enum logic {
        PH_DISPATCH = 1'b0,
        PH_SETTLE   = 1'b1
    } phase_e;

endpackage

// File: rtl/nib_seq_decode.sv
module nib_seq_decode
    import nib_seq_pkg::*;
(
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    output logic       two_byte,
    output logic [1:0] cost,
    output logic       addr_load,
    output logic       indirect,
    output logic       blocks_irq,
    output flow_e      flow
);

    logic escape;
    logic esc_load;

    always_comb begin
        escape   = (b0 == ESC_A) || (b0 == ESC_B);
        esc_load = (b0 == ESC_B) && (b1[7:6] == 2'b10) &&
                   (b1[3:0] >= 4'd1) && (b1[3:0] <= 4'd8);

        two_byte  = 1'b0;
        cost      = 2'd1;
        addr_load = 1'b0;
        indirect  = 1'b0;
        flow      = FL_PLAIN;

        if (escape) begin
            two_byte  = 1'b1;
            cost      = 2'd2;
            addr_load = esc_load;
        end else if (b0[7:2] == 6'b011000) begin
            two_byte = 1'b1;
            cost     = 2'd2;
            flow     = FL_LJMP;
        end else if (b0[7:2] == 6'b011010) begin
            two_byte = 1'b1;
            cost     = 2'd2;
            flow     = FL_LCALL;
        end else if ((b0 == IND_LOAD) || (b0 == IND_JUMP)) begin
            indirect = 1'b1;
            cost     = 2'd2;
        end else if (b0[7]) begin
            flow = FL_PAGE;
        end else if ((b0[7:6] == 2'b00) && b0[3]) begin
            addr_load = 1'b1;
        end

        blocks_irq = (flow != FL_PLAIN);
    end

endmodule

// File: rtl/nib_seq_target.sv
module nib_seq_target
    import nib_seq_pkg::*;
#(
    parameter int PC_W = 10
) (
    input  logic [PC_W-1:0] pc,
    input  logic [7:0]      b0,
    input  logic [7:0]      b1,
    input  flow_e           flow,
    input  logic            two_byte,
    output logic [PC_W-1:0] next_pc,
    output logic            push_en,
    output logic [PC_W-1:0] push_addr
);

    localparam int PAGE_LO = 6;
    localparam int HALF_LO = 7;

    logic [PC_W-1:0] pc1;
    logic [PC_W-1:0] pc2;
    logic            low_pages;

    always_comb begin
        pc1       = pc + PC_W'(1);
        pc2       = pc + PC_W'(2);
        low_pages = (pc1[9:7] == 3'b001);
        next_pc   = two_byte ? pc2 : pc1;
        push_en   = 1'b0;
        push_addr = pc2;

        unique case (flow)
            FL_LJMP: begin
                next_pc = PC_W'({b0[1:0], b1});
            end
            FL_LCALL: begin
                next_pc   = PC_W'({b0[1:0], b1});
                push_en   = 1'b1;
                push_addr = pc2;
            end
            FL_PAGE: begin
                if (low_pages) begin
                    next_pc = {pc1[PC_W-1:HALF_LO], b0[6:0]};
                end else if (b0[7:6] == 2'b11) begin
                    next_pc = {pc1[PC_W-1:PAGE_LO], b0[5:0]};
                end else begin
                    next_pc   = PC_W'({4'b0010, b0[5:0]});
                    push_en   = 1'b1;
                    push_addr = pc1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nib_seq.sv
module nib_seq
    import nib_seq_pkg::*;
#(
    parameter int              PC_W           = 10,
    parameter logic [PC_W-1:0] IRQ_VECTOR     = 'h0FF,
    parameter bit              RESTORE_ON_RET = 1'b1,
    parameter logic [7:0]      RET_OP         = 8'h48
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] rom_addr,
    output logic [PC_W-1:0] rom_addr_nxt,
    input  logic [7:0]      rom_byte0,
    input  logic [7:0]      rom_byte1,
    input  logic            wake_in,
    input  logic            dp_skip,
    input  logic            dp_pc_load,
    input  logic [PC_W-1:0] dp_pc_addr,
    input  logic            irq_en_load,
    input  logic            irq_en_val,
    output logic            exec_valid,
    output logic [7:0]      exec_op,
    output logic [7:0]      exec_arg,
    output logic            push_valid,
    output logic [PC_W-1:0] push_pc,
    output logic            step_valid,
    output logic [1:0]      step_kind,
    output logic [PC_W-1:0] step_pc,
    output logic [1:0]      step_cycles,
    output logic            irq_taken
);

    typedef struct packed {
        phase_e          phase;
        logic [PC_W-1:0] pc;
        logic            skip;
        logic            run;
        logic            saved_skip;
        logic            irq_en;
        logic            wake_hist;
        logic            exec_valid;
        logic [7:0]      exec_op;
        logic [7:0]      exec_arg;
        logic            push_valid;
        logic [PC_W-1:0] push_pc;
        logic            step_valid;
        step_kind_e      step_kind;
        logic [PC_W-1:0] step_pc;
        logic [1:0]      step_cycles;
        logic            irq_taken;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic            dec_two;
    logic [1:0]      dec_cost;
    logic            dec_load;
    logic            dec_ind;
    logic            dec_block;
    flow_e           dec_flow;
    logic [PC_W-1:0] tgt_pc;
    logic            tgt_push;
    logic [PC_W-1:0] tgt_push_addr;
    logic [PC_W-1:0] pc_past;
    logic            irq_fire;

    nib_seq_decode u_dec (
        .b0         (rom_byte0),
        .b1         (rom_byte1),
        .two_byte   (dec_two),
        .cost       (dec_cost),
        .addr_load  (dec_load),
        .indirect   (dec_ind),
        .blocks_irq (dec_block),
        .flow       (dec_flow)
    );

    nib_seq_target #(.PC_W(PC_W)) u_tgt (
        .pc        (state_q.pc),
        .b0        (rom_byte0),
        .b1        (rom_byte1),
        .flow      (dec_flow),
        .two_byte  (dec_two),
        .next_pc   (tgt_pc),
        .push_en   (tgt_push),
        .push_addr (tgt_push_addr)
    );

    always_comb begin
        state_d            = state_q;
        state_d.exec_valid = 1'b0;
        state_d.push_valid = 1'b0;
        state_d.step_valid = 1'b0;
        state_d.irq_taken  = 1'b0;

        pc_past  = state_q.pc + (dec_two ? PC_W'(2) : PC_W'(1));
        irq_fire = state_q.irq_en && state_q.wake_hist && !wake_in &&
                   !state_q.run && !dec_block;

        if (state_q.phase == PH_DISPATCH) begin
            state_d.step_valid = 1'b1;
            state_d.step_pc    = state_q.pc;
            if (irq_fire) begin
                state_d.irq_en      = 1'b0;
                state_d.saved_skip  = state_q.skip;
                state_d.skip        = 1'b0;
                state_d.push_valid  = 1'b1;
                state_d.push_pc     = state_q.pc;
                state_d.pc          = IRQ_VECTOR;
                state_d.irq_taken   = 1'b1;
                state_d.step_kind   = SK_IRQ;
                state_d.step_cycles = 2'd1;
            end else begin
                if (state_q.irq_en) begin
                    state_d.wake_hist = wake_in;
                end
                if (state_q.run && dec_load) begin
                    state_d.pc          = pc_past;
                    state_d.step_kind   = SK_DROP;
                    state_d.step_cycles = dec_cost;
                end else if (state_q.skip) begin
                    state_d.skip        = 1'b0;
                    state_d.run         = 1'b0;
                    state_d.pc          = pc_past;
                    state_d.step_kind   = SK_DROP;
                    state_d.step_cycles = dec_ind ? 2'd1 : dec_cost;
                end else begin
                    state_d.run         = dec_load;
                    state_d.pc          = tgt_pc;
                    state_d.push_valid  = tgt_push;
                    state_d.push_pc     = tgt_push_addr;
                    state_d.exec_valid  = 1'b1;
                    state_d.exec_op     = rom_byte0;
                    state_d.exec_arg    = dec_two ? rom_byte1 : 8'h00;
                    state_d.step_kind   = SK_EXEC;
                    state_d.step_cycles = dec_cost;
                    state_d.phase       = PH_SETTLE;
                end
            end
        end else begin
            state_d.phase = PH_DISPATCH;
            if (RESTORE_ON_RET && (state_q.exec_op == RET_OP)) begin
                state_d.skip = state_q.saved_skip;
            end else begin
                state_d.skip = dp_skip;
            end
            if (dp_pc_load) begin
                state_d.pc = dp_pc_addr;
            end
            if (irq_en_load) begin
                state_d.irq_en = irq_en_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rom_addr     = state_q.pc;
    assign rom_addr_nxt = state_q.pc + PC_W'(1);
    assign exec_valid   = state_q.exec_valid;
    assign exec_op      = state_q.exec_op;
    assign exec_arg     = state_q.exec_arg;
    assign push_valid   = state_q.push_valid;
    assign push_pc      = state_q.push_pc;
    assign step_valid   = state_q.step_valid;
    assign step_kind    = state_q.step_kind;
    assign step_pc      = state_q.step_pc;
    assign step_cycles  = state_q.step_cycles;
    assign irq_taken    = state_q.irq_taken;

endmodule

// File: rtl/nib_seq_chk.sv
module nib_seq_chk #(
    parameter int              PC_W       = 10,
    parameter logic [PC_W-1:0] IRQ_VECTOR = 'h0FF
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] rom_addr,
    input logic            exec_valid,
    input logic [7:0]      exec_op,
    input logic            push_valid,
    input logic [PC_W-1:0] push_pc,
    input logic            step_valid,
    input logic [1:0]      step_kind,
    input logic [PC_W-1:0] step_pc,
    input logic [1:0]      step_cycles,
    input logic            irq_taken
);

    // R3: an executed slot holds the strobe for exactly one settle clock
    p_exec_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid);

    // R3: the execute strobe always comes with an executed step report
    p_exec_is_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (step_valid && step_kind == 2'd0));

    // R3: a discarded slot produces no strobe and no push
    p_drop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_kind == 2'd1) |-> (!exec_valid && !push_valid));

    // R2: escape-opened instructions report a cost of two cycles
    p_escape_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && (exec_op == 8'h23 || exec_op == 8'h33)) |-> (step_cycles == 2'd2));

    // R7: a long call pushes its own address plus two
    p_lcall_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_op[7:2] == 6'b011010) |-> (push_valid && push_pc == step_pc + PC_W'(2)));

    // R11: interrupt entry vectors, pushes the pre-empted address and reports kind 2
    p_irq_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> (rom_addr == IRQ_VECTOR && push_valid && push_pc == step_pc &&
                       step_valid && step_kind == 2'd2 && step_cycles == 2'd1));

    // R11: the enable clears on entry, so entries never come back to back
    p_irq_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !irq_taken);

endmodule

bind nib_seq nib_seq_chk #(.PC_W(PC_W), .IRQ_VECTOR(IRQ_VECTOR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rom_addr    (rom_addr),
    .exec_valid  (exec_valid),
    .exec_op     (exec_op),
    .push_valid  (push_valid),
    .push_pc     (push_pc),
    .step_valid  (step_valid),
    .step_kind   (step_kind),
    .step_pc     (step_pc),
    .step_cycles (step_cycles),
    .irq_taken   (irq_taken)
);

// File: tb/tb_nib_seq.sv
module tb_nib_seq;

    localparam int PC_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] rom_addr, rom_addr_nxt;
    logic [7:0]      rom_byte0, rom_byte1;
    logic            wake_in = 1'b1;
    logic            dp_skip = 1'b0;
    logic            dp_pc_load = 1'b0;
    logic [PC_W-1:0] dp_pc_addr = '0;
    logic            irq_en_load = 1'b0;
    logic            irq_en_val = 1'b0;
    logic            exec_valid;
    logic [7:0]      exec_op, exec_arg;
    logic            push_valid;
    logic [PC_W-1:0] push_pc;
    logic            step_valid;
    logic [1:0]      step_kind;
    logic [PC_W-1:0] step_pc;
    logic [1:0]      step_cycles;
    logic            irq_taken;

    logic [7:0]      rom [0:1023];
    logic [PC_W-1:0] stack_q [$];
    logic [PC_W-1:0] drop_pc = '1;

    typedef struct {
        logic [1:0]      kind;
        logic [PC_W-1:0] pc;
        logic [1:0]      cyc;
        string           req;
    } exp_t;

    exp_t sb [$];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign rom_byte0 = rom[rom_addr];
    assign rom_byte1 = rom[rom_addr_nxt];

    nib_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rom_addr     (rom_addr),
        .rom_addr_nxt (rom_addr_nxt),
        .rom_byte0    (rom_byte0),
        .rom_byte1    (rom_byte1),
        .wake_in      (wake_in),
        .dp_skip      (dp_skip),
        .dp_pc_load   (dp_pc_load),
        .dp_pc_addr   (dp_pc_addr),
        .irq_en_load  (irq_en_load),
        .irq_en_val   (irq_en_val),
        .exec_valid   (exec_valid),
        .exec_op      (exec_op),
        .exec_arg     (exec_arg),
        .push_valid   (push_valid),
        .push_pc      (push_pc),
        .step_valid   (step_valid),
        .step_kind    (step_kind),
        .step_pc      (step_pc),
        .step_cycles  (step_cycles),
        .irq_taken    (irq_taken)
    );

    // driver side: expected step items
    task automatic expect_step(input logic [1:0] kind, input logic [PC_W-1:0] pc,
                               input logic [1:0] cyc, input string req);
        exp_t e;
        e.kind = kind; e.pc = pc; e.cyc = cyc; e.req = req;
        sb.push_back(e);
    endtask

    task automatic begin_case();
        @(negedge clk);
        rst_n   = 1'b0;
        wake_in = 1'b1;
        drop_pc = '1;
        for (int i = 0; i < 1024; i++) rom[i] = 8'h44;
        stack_q.delete();
        sb.delete();
        repeat (2) @(negedge clk);
        checks++;
        if (rom_addr !== '0 || exec_valid !== 1'b0 || push_valid !== 1'b0 ||
            step_valid !== 1'b0 || irq_taken !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs addr=%03h exec=%b push=%b step=%b irq=%b expected 000/0/0/0/0",
                     rom_addr, exec_valid, push_valid, step_valid, irq_taken);
        end
    endtask

    task automatic run_case(input string name);
        int waited;
        string first_req;
        first_req = (sb.size() > 0) ? sb[0].req : "none";
        @(negedge clk);
        rst_n  = 1'b1;
        waited = 0;
        while (sb.size() > 0 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s: case %s left %0d expected steps unseen, expected 0 (first pending %s)",
                     first_req, name, sb.size(), sb[0].req);
        end
    endtask

    // monitor and datapath responder, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            dp_skip     = 1'b0;
            dp_pc_load  = 1'b0;
            irq_en_load = 1'b0;
            irq_en_val  = 1'b0;
            if (rst_n) begin
                if (push_valid) stack_q.push_back(push_pc);
                if (step_valid) begin
                    if (sb.size() > 0) begin
                        exp_t e;
                        e = sb.pop_front();
                        checks++;
                        if (step_kind !== e.kind || step_pc !== e.pc || step_cycles !== e.cyc) begin
                            errors++;
                            $display("FAIL %s: step kind/pc/cycles got %0d/%03h/%0d expected %0d/%03h/%0d",
                                     e.req, step_kind, step_pc, step_cycles, e.kind, e.pc, e.cyc);
                        end
                    end
                    if (step_pc == drop_pc) wake_in = 1'b0;
                end
                if (exec_valid) begin
                    if (exec_op == 8'h20) dp_skip = 1'b1;
                    if (exec_op == 8'h48 && stack_q.size() > 0) begin
                        dp_pc_load = 1'b1;
                        dp_pc_addr = stack_q.pop_back();
                    end
                    if (exec_op == 8'h33 && exec_arg == 8'h62) begin
                        irq_en_load = 1'b1;
                        irq_en_val  = 1'b1;
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Case A: escapes, skip of 1- and 2-byte instructions, indirect skip cost
        begin_case();
        drop_pc = 10'h000;                 // R9: falling wake with enable clear is ignored
        rom[10'h000] = 8'h44;
        rom[10'h001] = 8'h23; rom[10'h002] = 8'h80;
        rom[10'h003] = 8'h20;
        rom[10'h004] = 8'h33; rom[10'h005] = 8'h50;
        rom[10'h006] = 8'h20;
        rom[10'h007] = 8'hFF;
        rom[10'h008] = 8'h20;
        rom[10'h009] = 8'h60; rom[10'h00A] = 8'h40;
        rom[10'h00B] = 8'h60; rom[10'h00C] = 8'h40;
        expect_step(2'd0, 10'h000, 2'd1, "R9");
        expect_step(2'd0, 10'h001, 2'd2, "R2");
        expect_step(2'd0, 10'h003, 2'd1, "R2");
        expect_step(2'd1, 10'h004, 2'd2, "R3");
        expect_step(2'd0, 10'h006, 2'd1, "R3");
        expect_step(2'd1, 10'h007, 2'd1, "R4");
        expect_step(2'd0, 10'h008, 2'd1, "R4");
        expect_step(2'd1, 10'h009, 2'd2, "R4");
        expect_step(2'd0, 10'h00B, 2'd2, "R3");
        expect_step(2'd0, 10'h040, 2'd1, "R7");
        run_case("skip");

        // Case B: address-load runs
        begin_case();
        rom[10'h000] = 8'h08;
        rom[10'h001] = 8'h09;
        rom[10'h002] = 8'h33; rom[10'h003] = 8'h81;
        rom[10'h004] = 8'h0F;
        rom[10'h005] = 8'h44;
        rom[10'h006] = 8'h0A;
        rom[10'h007] = 8'h44;
        rom[10'h008] = 8'h0B;
        rom[10'h009] = 8'h20;
        rom[10'h00A] = 8'h0C;
        rom[10'h00B] = 8'h0D;
        expect_step(2'd0, 10'h000, 2'd1, "R5");
        expect_step(2'd1, 10'h001, 2'd1, "R5");
        expect_step(2'd1, 10'h002, 2'd2, "R5");
        expect_step(2'd1, 10'h004, 2'd1, "R5");
        expect_step(2'd0, 10'h005, 2'd1, "R5");
        expect_step(2'd0, 10'h006, 2'd1, "R5");
        expect_step(2'd0, 10'h007, 2'd1, "R5");
        expect_step(2'd0, 10'h008, 2'd1, "R5");
        expect_step(2'd0, 10'h009, 2'd1, "R6");
        expect_step(2'd1, 10'h00A, 2'd1, "R6");
        expect_step(2'd0, 10'h00B, 2'd1, "R6");
        run_case("run");

        // Case C: long call, page jumps, page call
        begin_case();
        rom[10'h000] = 8'h68; rom[10'h001] = 8'h50;
        rom[10'h050] = 8'h48;
        rom[10'h002] = 8'h81;
        rom[10'h081] = 8'hC5;
        rom[10'h0C5] = 8'h48;
        rom[10'h003] = 8'hC9;
        expect_step(2'd0, 10'h000, 2'd2, "R7");
        expect_step(2'd0, 10'h050, 2'd1, "R7");
        expect_step(2'd0, 10'h002, 2'd1, "R7");
        expect_step(2'd0, 10'h081, 2'd1, "R8");
        expect_step(2'd0, 10'h0C5, 2'd1, "R8");
        expect_step(2'd0, 10'h003, 2'd1, "R8");
        expect_step(2'd0, 10'h009, 2'd1, "R8");
        run_case("jumps");

        // Case D: interrupt entry and return
        begin_case();
        rom[10'h000] = 8'h33; rom[10'h001] = 8'h62;
        rom[10'h100] = 8'h48;
        drop_pc = 10'h002;
        expect_step(2'd0, 10'h000, 2'd2, "R9");
        expect_step(2'd0, 10'h002, 2'd1, "R9");
        expect_step(2'd2, 10'h003, 2'd1, "R11");
        expect_step(2'd0, 10'h0FF, 2'd1, "R11");
        expect_step(2'd0, 10'h100, 2'd1, "R12");
        expect_step(2'd0, 10'h003, 2'd1, "R12");
        expect_step(2'd0, 10'h004, 2'd1, "R11");
        run_case("irq");

        // Case E: skip pending at interrupt entry is restored by the return
        begin_case();
        rom[10'h000] = 8'h33; rom[10'h001] = 8'h62;
        rom[10'h002] = 8'h20;
        rom[10'h003] = 8'h33; rom[10'h004] = 8'h50;
        rom[10'h100] = 8'h48;
        drop_pc = 10'h002;
        expect_step(2'd0, 10'h000, 2'd2, "R9");
        expect_step(2'd0, 10'h002, 2'd1, "R11");
        expect_step(2'd2, 10'h003, 2'd1, "R11");
        expect_step(2'd0, 10'h0FF, 2'd1, "R11");
        expect_step(2'd0, 10'h100, 2'd1, "R12");
        expect_step(2'd1, 10'h003, 2'd2, "R12");
        expect_step(2'd0, 10'h005, 2'd1, "R12");
        run_case("irq_skip");

        // Case F: a jump blocks entry and the edge is then consumed by the history
        begin_case();
        rom[10'h000] = 8'h33; rom[10'h001] = 8'h62;
        rom[10'h003] = 8'h60; rom[10'h004] = 8'h10;
        drop_pc = 10'h002;
        expect_step(2'd0, 10'h000, 2'd2, "R10");
        expect_step(2'd0, 10'h002, 2'd1, "R10");
        expect_step(2'd0, 10'h003, 2'd2, "R10");
        expect_step(2'd0, 10'h010, 2'd1, "R10");
        expect_step(2'd0, 10'h011, 2'd1, "R10");
        run_case("irq_jump_block");

        // Case G: an active run blocks entry
        begin_case();
        rom[10'h000] = 8'h33; rom[10'h001] = 8'h62;
        rom[10'h002] = 8'h08;
        rom[10'h003] = 8'h09;
        drop_pc = 10'h002;
        expect_step(2'd0, 10'h000, 2'd2, "R10");
        expect_step(2'd0, 10'h002, 2'd1, "R10");
        expect_step(2'd1, 10'h003, 2'd1, "R10");
        expect_step(2'd0, 10'h004, 2'd1, "R10");
        expect_step(2'd0, 10'h005, 2'd1, "R10");
        run_case("irq_run_block");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule